// File: doc/BRIEF.md
# Per-Target Priority Interrupt Selector

This block looks at every interrupt source on behalf of a single target and picks the one that should be served next. A source is a candidate when it is pending, is enabled for this target, and holds a nonzero priority. Among the candidates the highest priority wins, and the lower source number wins a tie. Source 0 is never a candidate, so ID 0 means that nothing is waiting.

The block presents the winner's ID and priority on registered outputs one clock after the inputs are sampled. The claim path uses the ID whatever the target's threshold is. A separate notify line drives the target's external interrupt input. Notify is raised only when the winner's priority is strictly above the threshold. The parent instantiates one copy for each target, sharing the pending and priority vectors and giving each copy its own enable vector and threshold.

Top module: `irq_target_arbiter`

## Requirements
- R1: A source whose priority field is 0 is never selected, even when it is pending and enabled.
- R2: Among candidates, the one with the numerically largest priority wins. Priority 1 is the weakest active level and the all-ones value (3 with 2-bit priorities) is the strongest.
- R3: When several candidates share the highest priority, the one with the smallest source ID wins.
- R4: `notify_o` is 1 only when a winner exists and its priority is strictly greater than `thresh_i`. A threshold of 0 therefore passes any nonzero priority.
- R5: `win_id_o` and `win_prio_o` do not depend on `thresh_i`. The winner is still reported when notify is held low by the threshold.
- R6: With no candidate, `win_id_o` = 0, `win_prio_o` = 0 and `notify_o` = 0.
- R7: Source 0 is never a candidate, whatever its pending, enable and priority bits are.
- R8: A source that is not pending, or not enabled, is ignored, whatever its priority.
- R9: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and a synchronous active-high reset drives all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NSRC | Pending bit per source, bit i = source i |
| en_i | input | NSRC | Enable bit per source for this target |
| prio_i | input | NSRC*PW | Priority of source i at bits [i*PW +: PW] |
| thresh_i | input | PW | Threshold of this target |
| win_id_o | output | $clog2(NSRC) | ID of the winning source, 0 when none |
| win_prio_o | output | PW | Priority of the winning source, 0 when none |
| notify_o | output | 1 | Interrupt request to the target |

## Verification
The claim selection and the threshold gate run in the same cycle from the same winner, so the bench drives vectors in which the winner sits at, below and above the threshold. For each vector it checks that the ID and priority match a reference computed without the threshold, and that notify follows the strict comparison. A tie at the top priority is combined with a threshold that blocks notify. This shows that the lowest-ID choice and the gating do not interfere. A long pseudo-random run then compares all three outputs against a bench-side reference model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Widest supported fields; instances use narrower parameters.
    localparam int unsigned MAX_ID_W   = 10;
    localparam int unsigned MAX_PRIO_W = 8;

    typedef struct packed {
        logic                  live;
        logic [MAX_PRIO_W-1:0] prio;
        logic [MAX_ID_W-1:0]   id;
    } cand_t;

    localparam cand_t CAND_NONE = '0;

    // lo always holds the lower IDs, so it keeps ties.
    function automatic cand_t pick(cand_t lo, cand_t hi);
        if (hi.live && (!lo.live || hi.prio > lo.prio))
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/irq_cand_mask.sv
module irq_cand_mask
    import irq_sel_pkg::*;
#(
    parameter int unsigned NSRC = 16,
    parameter int unsigned PW   = 2
) (
    input  logic [NSRC-1:0]     pend_i,
    input  logic [NSRC-1:0]     en_i,
    input  logic [NSRC*PW-1:0]  prio_i,
    output cand_t [NSRC-1:0]    cand_o
);

    // Source 0 is tied off; the others qualify on pend, enable and nonzero level.
    assign cand_o[0] = CAND_NONE;

    for (genvar i = 1; i < NSRC; i++) begin : g_src
        logic [PW-1:0] lvl;
        assign lvl            = prio_i[i*PW +: PW];
        assign cand_o[i].live = pend_i[i] & en_i[i] & (lvl != '0);
        assign cand_o[i].prio = MAX_PRIO_W'(lvl);
        assign cand_o[i].id   = MAX_ID_W'(i);
    end

endmodule

// File: rtl/irq_cmp_tree.sv
module irq_cmp_tree
    import irq_sel_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  cand_t [N-1:0] leaf_i,
    output cand_t         best_o
);

    localparam int unsigned LVL    = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned LEAVES = 1 << LVL;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    cand_t node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[LEAVES-1+i] = leaf_i[i];
        end else begin : g_pad
            assign node[LEAVES-1+i] = CAND_NONE;
        end
    end

    // Heap order: left child covers the lower IDs.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign node[k] = pick(node[2*k+1], node[2*k+2]);
    end

    assign best_o = node[0];

    always_comb begin
        if (!$isunknown(best_o) && best_o.live)
            p_live_nonzero_r1: assert (best_o.prio != '0 && best_o.id != '0);
    end

endmodule

// File: rtl/irq_target_arbiter.sv
module irq_target_arbiter
    import irq_sel_pkg::*;
#(
    parameter int unsigned NSRC = 16,
    parameter int unsigned PW   = 2,
    localparam int unsigned IDW = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     pend_i,
    input  logic [NSRC-1:0]     en_i,
    input  logic [NSRC*PW-1:0]  prio_i,
    input  logic [PW-1:0]       thresh_i,
    output logic [IDW-1:0]      win_id_o,
    output logic [PW-1:0]       win_prio_o,
    output logic                notify_o
);

    cand_t [NSRC-1:0] cands;
    cand_t            best;
    logic             above;

    irq_cand_mask #(.NSRC(NSRC), .PW(PW)) u_mask (
        .pend_i (pend_i),
        .en_i   (en_i),
        .prio_i (prio_i),
        .cand_o (cands)
    );

    irq_cmp_tree #(.N(NSRC)) u_tree (
        .leaf_i (cands),
        .best_o (best)
    );

    // Threshold gates only the notify line; the claim winner ignores it.
    assign above = best.live && (best.prio > MAX_PRIO_W'(thresh_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_id_o   <= '0;
            win_prio_o <= '0;
            notify_o   <= 1'b0;
        end else begin
            win_id_o   <= best.live ? best.id[IDW-1:0]  : '0;
            win_prio_o <= best.live ? best.prio[PW-1:0] : '0;
            notify_o   <= above;
        end
    end

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (win_id_o == '0) |-> (win_prio_o == '0 && !notify_o));

    p_notify_strict_r4: assert property (@(posedge clk) disable iff (rst)
        notify_o |-> (win_prio_o > $past(thresh_i)));

    p_winner_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        (win_id_o != '0) |-> (|($past(pend_i & en_i) & (NSRC'(1) << win_id_o))));

    p_winner_level_r2: assert property (@(posedge clk) disable iff (rst)
        (win_id_o != '0) |-> (win_prio_o == PW'($past(prio_i) >> (win_id_o * PW))));

    p_winner_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        (win_id_o != '0) |-> (win_prio_o != '0));

endmodule

// File: tb/irq_target_arbiter_test.sv
module irq_target_arbiter_test;

    localparam int NSRC = 16;
    localparam int PW   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pend = '0;
    logic [15:0] en   = '0;
    logic [31:0] prio = '0;
    logic [1:0]  thr  = '0;
    logic [3:0]  win_id;
    logic [1:0]  win_prio;
    logic        notify;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_target_arbiter #(.NSRC(NSRC), .PW(PW)) uut (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .prio_i(prio),
        .thresh_i(thr), .win_id_o(win_id), .win_prio_o(win_prio), .notify_o(notify)
    );

    typedef struct packed {
        logic [15:0] pend;
        logic [15:0] en;
        logic [31:0] prio;
        logic [1:0]  thr;
        logic [3:0]  id;
        logic [1:0]  p;
        logic        n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{16'h0000, 16'h0000, 32'h0000_0000, 2'd0, 4'd0,  2'd0, 1'b0}, // R6
        '{16'h0004, 16'h0004, 32'h0000_0010, 2'd0, 4'd2,  2'd1, 1'b1}, // R4 thr 0
        '{16'h0004, 16'h0004, 32'h0000_0010, 2'd1, 4'd2,  2'd1, 1'b0}, // R4 strict, R5
        '{16'h0006, 16'h0006, 32'h0000_0038, 2'd2, 4'd2,  2'd3, 1'b1}, // R2
        '{16'h8030, 16'hFFFF, 32'h8000_0A00, 2'd3, 4'd4,  2'd2, 1'b0}, // R3 + R5
        '{16'h0003, 16'h0003, 32'h0000_0003, 2'd0, 4'd0,  2'd0, 1'b0}, // R1, R7
        '{16'h0300, 16'h0100, 32'h000D_0000, 2'd0, 4'd8,  2'd1, 1'b1}, // R8 disabled
        '{16'h0100, 16'h0300, 32'h000D_0000, 2'd0, 4'd8,  2'd1, 1'b1}, // R8 not pending
        '{16'h8000, 16'h8000, 32'hC000_0000, 2'd2, 4'd15, 2'd3, 1'b1}, // R2 top ID
        '{16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 2'd0, 4'd1,  2'd3, 1'b1}  // R3, R7
    };
    string vtag [NV] = '{"R6", "R4", "R4/R5", "R2", "R3/R5", "R1/R7",
                         "R8", "R8", "R2", "R3/R7"};

    task automatic check(string tag, logic [3:0] eid, logic [1:0] ep, logic en_exp);
        checks++;
        if (win_id !== eid || win_prio !== ep || notify !== en_exp) begin
            errors++;
            $display("FAIL %s: got id=%0d prio=%0d notify=%0b expected id=%0d prio=%0d notify=%0b",
                     tag, win_id, win_prio, notify, eid, ep, en_exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic ref_model(input logic [15:0] pv, input logic [15:0] ev,
                             input logic [31:0] rv, input logic [1:0] tv,
                             output logic [3:0] oid, output logic [1:0] op,
                             output logic on);
        oid = '0; op = '0;
        for (int i = 1; i < NSRC; i++) begin
            logic [1:0] lv;
            lv = rv[i*PW +: PW];
            if (pv[i] && ev[i] && lv != 0 && lv > op) begin
                oid = 4'(i); op = lv;
            end
        end
        on = (op != 0) && (op > tv);
    endtask

    task automatic apply(logic [15:0] pv, logic [15:0] ev, logic [31:0] rv, logic [1:0] tv);
        pend = pv; en = ev; prio = rv; thr = tv;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] rid;
        logic [1:0] rp;
        logic       rn;
        repeat (3) @(negedge clk);
        check("R9 reset", 4'd0, 2'd0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", 4'd0, 2'd0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            apply(VT[v].pend, VT[v].en, VT[v].prio, VT[v].thr);
            @(negedge clk);
            check(vtag[v], VT[v].id, VT[v].p, VT[v].n);
        end

        // R9: one-cycle latency; the output still holds the old value just after new inputs.
        apply(16'h0000, 16'h0000, 32'h0, 2'd0);
        @(negedge clk);
        apply(16'h8000, 16'h8000, 32'hC000_0000, 2'd0);
        #1 check("R9 latency before edge", 4'd0, 2'd0, 1'b0);
        @(negedge clk);
        check("R9 latency after edge", 4'd15, 2'd3, 1'b1);

        // R9: reset with an active winner clears the outputs.
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset while active", 4'd0, 2'd0, 1'b0);
        rst = 1'b0;

        // R4: threshold equal to the winner's level blocks notify but keeps the ID (R5).
        apply(16'h0020, 16'h0020, 32'h0000_0C00, 2'd3);
        @(negedge clk);
        check("R4/R5 thr equal max", 4'd5, 2'd3, 1'b0);

        // R3: a tie between two sources, changing only the lower one's enable.
        apply(16'h0C00, 16'h0800, 32'h00A0_0000, 2'd0);
        @(negedge clk);
        check("R3/R8 tie partner disabled", 4'd11, 2'd2, 1'b1);

        // Pseudo-random comparison against the reference model (R2 R3 R4 R5).
        for (int k = 0; k < 400; k++) begin
            logic [15:0] pv, ev;
            logic [31:0] rv;
            logic [1:0]  tv;
            pv = 16'($urandom); ev = 16'($urandom); rv = $urandom; tv = 2'($urandom);
            apply(pv, ev, rv, tv);
            ref_model(pv, ev, rv, tv, rid, rp, rn);
            @(negedge clk);
            check("R2/R3/R4/R5 random", rid, rp, rn);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule